// File: doc/BRIEF.md
# Cache Maintenance Operation Engine

This block is the maintenance side of a set-associative second-level cache. It keeps the valid, dirty and tag state of every line. It takes requests from a register bus to clean a line, invalidate it, or clean and then invalidate it. A request names its target in one of two ways. The first is a bitmask of ways: every set of each selected way is processed in the background. The second is a physical address: only the one line holding that address is processed. A line that must reach memory leaves the block as a write-back request on a valid/ready port.

A by-way operation walks one set per cycle. Each way's bit in the mask clears as soon as that way is finished, so software polls the mask register until it reads zero. Writing the sync register raises a drain flag, which stays up until all maintenance has finished. A small access port stands for the cache's lookup path: each access either marks a line dirty or allocates a line. Two debug bits change what an access does: one forces write-through, the other suppresses line fills. Software sets them while maintenance runs.

Top module: `cme_engine`

## Requirements
- R1: After reset the control, auxiliary and debug registers read 0, and `busy`, `wb_valid` and `sync_wait` are low.
- R2: Auxiliary-register writes are ignored while control bit 0 (cache enable) is set. Accesses have no effect while that bit is clear.
- R3: Auxiliary bit 16 chooses 16 ways (1) or 8 ways (0). Mask bits at or above the way count are dropped when a by-way operation starts, and the way-mask register reads back the truncated mask.
- R4: A by-way operation handles one set per cycle, visiting the selected ways in ascending order. A way's mask bit clears on the cycle its last set is handled, and the way-mask register reads 0 once every requested way is done.
- R5: A clean raises a write-back request only for a line that is both valid and dirty. The request carries the line-aligned address {tag, set, 5'b0}. After the clean the line is no longer dirty.
- R6: An invalidate clears the line's valid bit and raises no request. A clean-and-invalidate raises the request first and then invalidates the line.
- R7: A by-address write acts on the 32-byte line that contains the address, so address bits [4:0] are ignored. It does nothing if no way of that set holds a matching valid tag.
- R8: While an operation runs, `busy` and control read bit 1 are high, and any new by-way or by-address write is ignored.
- R9: `wb_valid` stays high with a stable `wb_addr` until `wb_ready` is seen, and the walker stalls on that line meanwhile.
- R10: Debug bit 1 set: a write access does not set the dirty bit. Debug bit 0 set: a missing access does not allocate a line.
- R11: A write to the sync register sets `sync_wait` (sync read bit 0). The flag stays high while an operation runs and clears one cycle after the engine is idle.
- R12: An access to a line in the same cycle as a maintenance update of that line is applied after the update, so a write access leaves the line dirty.
- R13: A by-way operation that is already running completes every requested way, even if the way count is lowered while it runs.

Register offsets: control 0x100, auxiliary 0x104, sync 0x730, debug 0xF40. Each operation group has a by-address register at its base and a by-way register at base+0xC. The group bases are 0x770 (invalidate), 0x7B0 (clean) and 0x7F0 (clean-and-invalidate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data the next cycle) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| acc_en | input | 1 | Cache access strobe |
| acc_write | input | 1 | Access is a write |
| acc_way | input | 4 | Way chosen for the access |
| acc_line | input | 27 | Line address of the access (address bits 31:5) |
| wb_valid | output | 1 | Write-back request pending |
| wb_addr | output | 32 | Line-aligned write-back address |
| wb_ready | input | 1 | Write-back accepted |
| busy | output | 1 | A maintenance operation is in progress |
| sync_wait | output | 1 | Sync drain still outstanding |

## Verification
Two things can touch the same tag entry in one cycle: a maintenance update and an access. The bench creates this collision with a by-address clean of a dirty line while `wb_ready` is held high. The write-back handshake then completes on the second edge after the register write. The bench places a write access to that same line on exactly that edge. It judges the outcome by issuing a second clean: this must produce a second write-back, which shows the access was applied after the dirty bit was cleared.

// File: rtl/cme_pkg.sv
package cme_pkg;
  typedef enum logic [1:0] {OP_INV = 2'd0, OP_CLEAN = 2'd1, OP_CINV = 2'd2} mop_t;

  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFF_CTL       = 12'h100;
  localparam logic [REG_AW-1:0] OFF_AUX       = 12'h104;
  localparam logic [REG_AW-1:0] OFF_SYNC      = 12'h730;
  localparam logic [REG_AW-1:0] OFF_DBG       = 12'hF40;
  localparam logic [REG_AW-1:0] OFF_GRP_INV   = 12'h770;
  localparam logic [REG_AW-1:0] OFF_GRP_CLEAN = 12'h7B0;
  localparam logic [REG_AW-1:0] OFF_GRP_CINV  = 12'h7F0;
  localparam logic [REG_AW-1:0] OFF_WAY_SEL   = 12'h00C;
  localparam int AUX_WIDE_BIT = 16;
endpackage

// File: rtl/cme_regs.sv
module cme_regs
  import cme_pkg::*;
#(
  parameter int MAX_WAYS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  input  logic                busy,
  input  logic                walking,
  input  mop_t                run_op,
  input  logic [MAX_WAYS-1:0] run_mask,
  output logic [31:0]         reg_rdata,
  output logic                cache_en,
  output logic [31:0]         aux_q,
  output logic [1:0]          dbg_q,
  output logic                start_way,
  output logic                start_line,
  output mop_t                start_op,
  output logic [MAX_WAYS-1:0] start_mask,
  output logic                sync_wait
);
  localparam int HALF = MAX_WAYS / 2;

  logic                is_pa, is_way;
  logic [MAX_WAYS-1:0] ways_mask;
  logic [31:0]         rd_val;

  always_comb begin
    is_pa  = 1'b0;
    is_way = 1'b0;
    start_op = OP_INV;
    case (reg_addr)
      OFF_GRP_INV:                 begin is_pa  = 1'b1; start_op = OP_INV;   end
      OFF_GRP_INV + OFF_WAY_SEL:   begin is_way = 1'b1; start_op = OP_INV;   end
      OFF_GRP_CLEAN:               begin is_pa  = 1'b1; start_op = OP_CLEAN; end
      OFF_GRP_CLEAN + OFF_WAY_SEL: begin is_way = 1'b1; start_op = OP_CLEAN; end
      OFF_GRP_CINV:                begin is_pa  = 1'b1; start_op = OP_CINV;  end
      OFF_GRP_CINV + OFF_WAY_SEL:  begin is_way = 1'b1; start_op = OP_CINV;  end
      default: ;
    endcase
  end

  assign ways_mask  = aux_q[AUX_WIDE_BIT] ? {MAX_WAYS{1'b1}} : {{(MAX_WAYS-HALF){1'b0}}, {HALF{1'b1}}};
  assign start_mask = reg_wdata[MAX_WAYS-1:0] & ways_mask;
  assign start_way  = reg_wr && is_way && !busy && (start_mask != '0);
  assign start_line = reg_wr && is_pa && !busy;

  function automatic logic [31:0] mask_view(input mop_t grp);
    return (walking && run_op == grp) ? 32'(run_mask) : 32'd0;
  endfunction

  always_comb begin
    case (reg_addr)
      OFF_CTL:                     rd_val = {30'd0, busy, cache_en};
      OFF_AUX:                     rd_val = aux_q;
      OFF_DBG:                     rd_val = {30'd0, dbg_q};
      OFF_SYNC:                    rd_val = {31'd0, sync_wait};
      OFF_GRP_INV + OFF_WAY_SEL:   rd_val = mask_view(OP_INV);
      OFF_GRP_CLEAN + OFF_WAY_SEL: rd_val = mask_view(OP_CLEAN);
      OFF_GRP_CINV + OFF_WAY_SEL:  rd_val = mask_view(OP_CINV);
      default:                     rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_en  <= 1'b0;
      aux_q     <= '0;
      dbg_q     <= '0;
      sync_wait <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_CTL) cache_en <= reg_wdata[0];
      if (reg_wr && reg_addr == OFF_AUX && !cache_en) aux_q <= reg_wdata;
      if (reg_wr && reg_addr == OFF_DBG) dbg_q <= reg_wdata[1:0];
      if (reg_wr && reg_addr == OFF_SYNC) sync_wait <= 1'b1;
      else if (!busy) sync_wait <= 1'b0;
      if (reg_rd) reg_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/cme_tags.sv
module cme_tags #(
  parameter int WAYS  = 16,
  parameter int SETS  = 16,
  parameter int TAG_W = 23,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAYS-1:0]  rd_valid,
  output logic [WAYS-1:0]  rd_dirty,
  output logic [TAG_W-1:0] rd_tag [WAYS],
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_way,
  input  logic             upd_inval,
  input  logic             acc_en,
  input  logic             acc_write,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [SET_W-1:0] acc_set,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             wt,
  input  logic             nofill
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic             acc_hit;
  logic             mark_dirty;

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  always_comb begin
    for (int w = 0; w < WAYS; w++) rd_tag[w] = tag_q[rd_set][w];
  end

  assign acc_hit    = valid_q[acc_set][acc_way] && (tag_q[acc_set][acc_way] == acc_tag);
  assign mark_dirty = acc_write && !wt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (upd_en) begin
        dirty_q[rd_set][upd_way] <= 1'b0;
        if (upd_inval) valid_q[rd_set][upd_way] <= 1'b0;
      end
      if (acc_en) begin
        if (acc_hit) begin
          if (mark_dirty) begin
            valid_q[acc_set][acc_way] <= 1'b1;
            dirty_q[acc_set][acc_way] <= 1'b1;
          end
        end else if (!nofill) begin
          valid_q[acc_set][acc_way] <= 1'b1;
          dirty_q[acc_set][acc_way] <= mark_dirty;
          tag_q[acc_set][acc_way]   <= acc_tag;
        end
      end
    end
  end
endmodule

// File: rtl/cme_seq.sv
module cme_seq
  import cme_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int SETS  = 16,
  parameter int TAG_W = 23,
  parameter int OFF_W = 5,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = TAG_W + SET_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_way,
  input  logic                    start_line,
  input  mop_t                    start_op,
  input  logic [WAYS-1:0]         start_mask,
  input  logic [LINE_W-1:0]       start_addr,
  input  logic [WAYS-1:0]         rd_valid,
  input  logic [WAYS-1:0]         rd_dirty,
  input  logic [TAG_W-1:0]        rd_tag [WAYS],
  input  logic                    wb_ready,
  output logic [SET_W-1:0]        rd_set,
  output logic                    upd_en,
  output logic [WAY_W-1:0]        upd_way,
  output logic                    upd_inval,
  output logic                    wb_valid,
  output logic [LINE_W+OFF_W-1:0] wb_addr,
  output logic                    busy,
  output logic                    walking,
  output mop_t                    run_op,
  output logic [WAYS-1:0]         run_mask
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_LINE} st_t;

  st_t               state;
  logic [WAY_W-1:0]  way_q, hit_way, cur_way;
  logic [SET_W-1:0]  set_q;
  logic [LINE_W-1:0] line_q;
  logic              line_hit, active, need_wb, step;

  assign rd_set = (state == S_LINE) ? line_q[SET_W-1:0] : set_q;

  always_comb begin
    line_hit = 1'b0;
    hit_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!line_hit && rd_valid[w] && rd_tag[w] == line_q[LINE_W-1:SET_W]) begin
        line_hit = 1'b1;
        hit_way  = WAY_W'(w);
      end
    end
  end

  assign cur_way = (state == S_LINE) ? hit_way : way_q;
  assign active  = (state == S_WALK && run_mask[way_q]) || (state == S_LINE && line_hit);
  assign need_wb = active && run_op != OP_INV && rd_valid[cur_way] && rd_dirty[cur_way];
  assign step    = active && (!need_wb || (wb_valid && wb_ready));

  assign upd_en    = step;
  assign upd_way   = cur_way;
  assign upd_inval = run_op != OP_CLEAN;
  assign busy      = state != S_IDLE;
  assign walking   = state == S_WALK;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      run_op   <= OP_INV;
      run_mask <= '0;
      way_q    <= '0;
      set_q    <= '0;
      line_q   <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
    end else begin
      if (need_wb && !wb_valid) begin
        wb_valid <= 1'b1;
        wb_addr  <= {rd_tag[cur_way], rd_set, {OFF_W{1'b0}}};
      end
      if (step) wb_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_way) begin
            state    <= S_WALK;
            run_op   <= start_op;
            run_mask <= start_mask;
            way_q    <= '0;
            set_q    <= '0;
          end else if (start_line) begin
            state  <= S_LINE;
            run_op <= start_op;
            line_q <= start_addr;
          end
        end
        S_WALK: begin
          if (run_mask == '0) state <= S_IDLE;
          else if (!run_mask[way_q]) way_q <= way_q + 1'b1;
          else if (step) begin
            if (set_q == SET_W'(SETS - 1)) begin
              run_mask[way_q] <= 1'b0;
              set_q <= '0;
              way_q <= way_q + 1'b1;
            end else begin
              set_q <= set_q + 1'b1;
            end
          end
        end
        S_LINE: begin
          if (!line_hit || step) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cme_engine.sv
module cme_engine
  import cme_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_WAYS   = 16,
  parameter int SETS       = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(MAX_WAYS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [WAY_W-1:0]  acc_way,
  input  logic [LINE_W-1:0] acc_line,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ready,
  output logic              busy,
  output logic              sync_wait
);
  logic                cache_en, walking, start_way, start_line;
  logic [31:0]         aux_q;
  logic [1:0]          dbg_q;
  mop_t                start_op, run_op;
  logic [MAX_WAYS-1:0] start_mask, run_mask, rd_valid, rd_dirty;
  logic [TAG_W-1:0]    rd_tag [MAX_WAYS];
  logic [SET_W-1:0]    rd_set;
  logic                upd_en, upd_inval;
  logic [WAY_W-1:0]    upd_way;

  cme_regs #(.MAX_WAYS(MAX_WAYS)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .walking(walking), .run_op(run_op),
    .run_mask(run_mask), .reg_rdata(reg_rdata), .cache_en(cache_en), .aux_q(aux_q),
    .dbg_q(dbg_q), .start_way(start_way), .start_line(start_line), .start_op(start_op),
    .start_mask(start_mask), .sync_wait(sync_wait)
  );

  cme_seq #(.WAYS(MAX_WAYS), .SETS(SETS), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst(rst), .start_way(start_way), .start_line(start_line),
    .start_op(start_op), .start_mask(start_mask), .start_addr(reg_wdata[ADDR_W-1:OFF_W]),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .wb_ready(wb_ready),
    .rd_set(rd_set), .upd_en(upd_en), .upd_way(upd_way), .upd_inval(upd_inval),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .busy(busy), .walking(walking),
    .run_op(run_op), .run_mask(run_mask)
  );

  cme_tags #(.WAYS(MAX_WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .rd_set(rd_set), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_tag(rd_tag), .upd_en(upd_en), .upd_way(upd_way), .upd_inval(upd_inval),
    .acc_en(acc_en && cache_en), .acc_write(acc_write), .acc_way(acc_way),
    .acc_set(acc_line[SET_W-1:0]), .acc_tag(acc_line[LINE_W-1:SET_W]),
    .wt(dbg_q[1]), .nofill(dbg_q[0])
  );
endmodule

// File: rtl/cme_checker.sv
module cme_checker
  import cme_pkg::*;
#(
  parameter int MAX_WAYS = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic [REG_AW-1:0]   reg_addr,
  input logic                wb_valid,
  input logic                wb_ready,
  input logic [31:0]         wb_addr,
  input logic                busy,
  input logic                walking,
  input logic [MAX_WAYS-1:0] run_mask,
  input logic                sync_wait,
  input logic                cache_en,
  input logic [31:0]         aux_q
);
  assert_wb_hold_R9: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  assert_wb_busy_R5: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> busy);

  assert_mask_shrink_R4: assert property (@(posedge clk) disable iff (rst)
    walking && $past(walking) |-> (run_mask & ~$past(run_mask)) == '0);

  assert_one_way_R4: assert property (@(posedge clk) disable iff (rst)
    walking |-> $countones($past(run_mask) & ~run_mask) <= 1);

  assert_sync_clear_R11: assert property (@(posedge clk) disable iff (rst)
    sync_wait && !busy && !(reg_wr && reg_addr == OFF_SYNC) |=> !sync_wait);

  assert_aux_lock_R2: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == OFF_AUX && cache_en |=> $stable(aux_q));

  assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(walking) |-> !$past(busy));
endmodule

bind cme_engine cme_checker #(.MAX_WAYS(MAX_WAYS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_addr(wb_addr), .busy(busy), .walking(walking),
  .run_mask(run_mask), .sync_wait(sync_wait), .cache_en(cache_en), .aux_q(aux_q)
);

// File: tb/cme_engine_test.sv
module cme_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTL = 12'h100, A_AUX = 12'h104, A_SYNC = 12'h730, A_DBG = 12'hF40;
  localparam logic [11:0] A_INV = 12'h770, A_CLN = 12'h7B0, A_CINV = 12'h7F0, WSEL = 12'h00C;

  localparam int NV = 8;
  localparam logic [31:0] V_ACC [NV] = '{32'h1000, 32'h1000, 32'h1000, 32'h1000,
                                          32'h1000, 32'h1000, 32'h1000, 32'h1000};
  localparam logic        V_WR  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [11:0] V_OP  [NV] = '{A_CLN, A_INV, A_CINV, A_CLN, A_CLN, A_CLN, A_INV, A_CINV};
  localparam logic [31:0] V_OPA [NV] = '{32'h1000, 32'h1000, 32'h1000, 32'h1000,
                                          32'h101F, 32'h1020, 32'h2000, 32'h1010};
  localparam int          V_EXP [NV] = '{1, 0, 1, 0, 1, 0, 0, 1};
  localparam int          V_PRB [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic acc_en = 1'b0, acc_write = 1'b0;
  logic [3:0] acc_way = '0;
  logic [26:0] acc_line = '0;
  logic wb_valid, wb_ready = 1'b1, busy, sync_wait;
  logic [31:0] wb_addr;

  int checks = 0, failures = 0, wb_cnt = 0;
  logic [31:0] wb_last = '0;
  bit done = 1'b0;

  cme_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_en(acc_en), .acc_write(acc_write),
    .acc_way(acc_way), .acc_line(acc_line), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_ready(wb_ready), .busy(busy), .sync_wait(sync_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (wb_valid && wb_ready) begin
    wb_cnt++;
    wb_last = wb_addr;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic access(input logic [31:0] a, input logic w);
    @(negedge clk); acc_en = 1'b1; acc_write = w; acc_line = a[31:5];
    @(negedge clk); acc_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr(A_INV + WSEL, 32'hFF);
    wait_idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_CTL, v); check("R1 ctl", v, 0);
    rd(A_AUX, v); check("R1 aux", v, 0);
    rd(A_DBG, v); check("R1 dbg", v, 0);
    check("R1 outputs", {busy, wb_valid, sync_wait}, 0);

    wr(A_CTL, 1);
    // R2 aux locked while enabled
    wr(A_AUX, 32'h10000);
    rd(A_AUX, v); check("R2 aux locked", v, 0);

    // R3 8-way truncation
    wr(A_INV + WSEL, 32'hFFFF);
    rd(A_INV + WSEL, v); check("R3 truncated mask", v, 32'h00FF);
    wait_idle();
    rd(A_INV + WSEL, v); check("R3 done", v, 0);

    // table: R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      clear_all();
      access(V_ACC[i], V_WR[i]);
      c0 = wb_cnt;
      wr(V_OP[i], V_OPA[i]);
      wait_idle();
      check($sformatf("R5 R6 R7 vec%0d op wb", i), wb_cnt - c0, V_EXP[i]);
      if (V_EXP[i] != 0) check($sformatf("R5 vec%0d addr", i), wb_last, 32'h1000);
      c0 = wb_cnt;
      wr(A_CLN, V_ACC[i]);
      wait_idle();
      check($sformatf("R5 R6 R7 vec%0d probe", i), wb_cnt - c0, V_PRB[i]);
    end

    // R4 walker timing, mask 0x3
    clear_all();
    wr(A_CLN + WSEL, 32'h3);
    repeat (9) @(negedge clk);
    rd(A_CLN + WSEL, v); check("R4 both pending", v, 32'h3);
    repeat (6) @(negedge clk);
    rd(A_CLN + WSEL, v); check("R4 way0 cleared", v, 32'h2);
    repeat (15) @(negedge clk);
    rd(A_CLN + WSEL, v); check("R4 all cleared", v, 0);
    check("R4 idle", busy, 0);

    // R9 write-back stall
    clear_all();
    access(32'h3000, 1'b1);
    wb_ready = 1'b0;
    wr(A_CLN, 32'h3000);
    repeat (5) @(negedge clk);
    check("R9 held", {wb_valid, busy}, 2'b11);
    check("R9 addr", wb_addr, 32'h3000);
    c0 = wb_cnt;
    wb_ready = 1'b1;
    wait_idle();
    check("R9 one handshake", wb_cnt - c0, 1);
    check("R9 released", wb_valid, 0);

    // R8 writes ignored while busy
    clear_all();
    access(32'h1000, 1'b1);
    c0 = wb_cnt;
    wr(A_CLN + WSEL, 32'h2);
    wr(A_CLN, 32'h1000);
    wr(A_INV + WSEL, 32'h1);
    rd(A_INV + WSEL, v); check("R8 second way op ignored", v, 0);
    rd(A_CTL, v); check("R8 busy bit", v, 32'h3);
    wait_idle();
    check("R8 line op ignored", wb_cnt - c0, 0);
    wr(A_CLN, 32'h1000);
    wait_idle();
    check("R8 line survived", wb_cnt - c0, 1);

    // R10 debug bits
    clear_all();
    wr(A_DBG, 2);
    access(32'h1000, 1'b1);
    c0 = wb_cnt;
    wr(A_CLN, 32'h1000); wait_idle();
    check("R10 write-through", wb_cnt - c0, 0);
    wr(A_DBG, 1);
    access(32'h5000, 1'b1);
    wr(A_DBG, 0);
    wr(A_CLN, 32'h5000); wait_idle();
    check("R10 no fill", wb_cnt - c0, 0);
    access(32'h5000, 1'b1);
    wr(A_CLN, 32'h5000); wait_idle();
    check("R10 normal fill", wb_cnt - c0, 1);

    // R11 sync drain
    wr(A_INV + WSEL, 32'hFF);
    wr(A_SYNC, 0);
    rd(A_SYNC, v); check("R11 sync pending", v, 1);
    check("R11 port", sync_wait, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    rd(A_SYNC, v); check("R11 sync done", v, 0);
    check("R11 port clear", sync_wait, 0);

    // R12 same-cycle access and clean
    clear_all();
    access(32'h1000, 1'b1);
    c0 = wb_cnt;
    wr(A_CLN, 32'h1000);
    access(32'h1000, 1'b1);
    wait_idle();
    check("R12 first clean", wb_cnt - c0, 1);
    wr(A_CLN, 32'h1000); wait_idle();
    check("R12 redirtied", wb_cnt - c0, 2);

    // R13 way count lowered mid-operation
    wr(A_CTL, 0);
    wr(A_AUX, 32'h10000);
    wr(A_INV + WSEL, 32'hFFFF);
    wr(A_AUX, 32'h0);
    repeat (137) @(negedge clk);
    rd(A_INV + WSEL, v); check("R13 upper ways pending", v, 32'hFF00);
    wait_idle();
    rd(A_INV + WSEL, v); check("R13 completed", v, 0);

    // R2 access ignored while disabled
    access(32'h6000, 1'b1);
    wr(A_CTL, 1);
    c0 = wb_cnt;
    wr(A_CLN, 32'h6000); wait_idle();
    check("R2 disabled access", wb_cnt - c0, 0);

    finish_run();
  end
endmodule